// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between a processor's memory stage and a 32-bit word-wide data memory. For each request it forms the effective address from a base register and a signed 16-bit displacement. It drives the word address to memory. On stores it also drives four byte-lane write enables and write data moved into the addressed lanes. On loads it takes the word that memory returns one cycle later. It picks the addressed byte, halfword or word out of that word and extends the value to 32 bits, with either the sign bit or zeros.

Byte lanes are numbered big-endian: byte offset 0 in a word is bits 31:24. A halfword access at an odd address is flagged as misaligned. So is a word access whose low two address bits are not both zero. A flagged access never reaches memory. An opcode outside the supported set is dropped without any effect.

Top module: `lsu_align_top`

## Requirements
- R1: The effective address is `base_i` plus `disp_i` sign-extended to 32 bits. `mem_addr_o` carries its bits 31:2, and its low two bits are the byte offset within the word.
- R2: Only these opcodes are served: 0x20 signed byte load, 0x21 signed halfword load, 0x23 word load, 0x24 unsigned byte load, 0x25 unsigned halfword load, 0x28 byte store, 0x29 halfword store, 0x2b word store. Any other opcode raises neither `mem_req_o` nor `misalign_o`, and it produces no `load_done_o`.
- R3: On an aligned store, `mem_be_o` bit i enables bits 8i+7:8i. A byte store enables bit 3-offset. A halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store enables 4'b1111. On a load, `mem_be_o` is 0.
- R4: On a store, the low 1, 2 or 4 bytes of `store_data_i` appear in the enabled lanes of `mem_wdata_o`, with the more significant byte in the lower offset. Lanes that are not enabled carry zero.
- R5: A halfword access with offset bit 0 set, or a word access with a nonzero offset, raises `misalign_o`. Such an access holds `mem_req_o` and `mem_we_o` low, leaves memory unchanged and produces no `load_done_o`. Byte accesses are never misaligned.
- R6: An accepted load raises `load_done_o` for exactly one cycle, on the cycle after the request, when `mem_rdata_i` holds the addressed word. A store produces no `load_done_o`.
- R7: Signed byte and halfword loads copy the top bit of the selected field into all upper bits of `load_data_o`.
- R8: Unsigned byte and halfword loads fill the upper bits of `load_data_o` with zeros. A word load returns the whole memory word.
- R9: While `rst_ni` is low, `load_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid this cycle |
| opcode_i | input | 6 | Access opcode |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| store_data_i | input | 32 | Register value to store |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte-lane write enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rdata_i | input | 32 | Read word, one cycle after the request |
| misalign_o | output | 1 | Misaligned access flag |
| load_done_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The hardest case to reach is a misaligned store that must leave memory untouched. The missing write is only visible when a later load of the same word returns the earlier value. The bench therefore follows each misaligned store with an aligned word load of that word, and it compares the result against its own memory model.

Sign extension is the other case that needs care. The bench seeds memory words whose byte and halfword fields have the top bit alternately set and clear. It then reads each offset of those words with both the signed and the unsigned opcodes.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  localparam logic [5:0] OP_LDB  = 6'h20;
  localparam logic [5:0] OP_LDH  = 6'h21;
  localparam logic [5:0] OP_LDW  = 6'h23;
  localparam logic [5:0] OP_LDBU = 6'h24;
  localparam logic [5:0] OP_LDHU = 6'h25;
  localparam logic [5:0] OP_STB  = 6'h28;
  localparam logic [5:0] OP_STH  = 6'h29;
  localparam logic [5:0] OP_STW  = 6'h2b;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      valid;
    logic      is_store;
    logic      is_signed;
    acc_size_e size;
  } acc_ctrl_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [5:0] opcode_i,
  output acc_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '{valid: 1'b0, is_store: 1'b0, is_signed: 1'b0, size: SZ_BYTE};
    unique case (opcode_i)
      OP_LDB:  ctrl_o = '{valid: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: SZ_BYTE};
      OP_LDH:  ctrl_o = '{valid: 1'b1, is_store: 1'b0, is_signed: 1'b1, size: SZ_HALF};
      OP_LDW:  ctrl_o = '{valid: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_WORD};
      OP_LDBU: ctrl_o = '{valid: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_BYTE};
      OP_LDHU: ctrl_o = '{valid: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_HALF};
      OP_STB:  ctrl_o = '{valid: 1'b1, is_store: 1'b1, is_signed: 1'b0, size: SZ_BYTE};
      OP_STH:  ctrl_o = '{valid: 1'b1, is_store: 1'b1, is_signed: 1'b0, size: SZ_HALF};
      OP_STW:  ctrl_o = '{valid: 1'b1, is_store: 1'b1, is_signed: 1'b0, size: SZ_WORD};
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o    = base_i + disp_sx;
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_pkg::*;
(
  input  acc_ctrl_t         ctrl_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misalign_o
);
  always_comb begin
    unique case (ctrl_i.size)
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b0;
    endcase
  end

  // lane l holds big-endian byte offset LANES-1-l
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int BO = LANES - 1 - l;
    localparam logic [OFF_W-1:0] BO_V = OFF_W'(BO);
    localparam int HSRC = (BO % 2 == 0) ? 1 : 0;
    logic       sel;
    logic [7:0] byte_v;

    always_comb begin
      sel    = 1'b0;
      byte_v = 8'h00;
      unique case (ctrl_i.size)
        SZ_BYTE: begin
          sel    = (off_i == BO_V);
          byte_v = store_data_i[7:0];
        end
        SZ_HALF: begin
          sel    = (off_i[OFF_W-1:1] == BO_V[OFF_W-1:1]);
          byte_v = store_data_i[8*HSRC +: 8];
        end
        SZ_WORD: begin
          sel    = 1'b1;
          byte_v = store_data_i[8*l +: 8];
        end
        default: ;
      endcase
    end

    assign lane_en_o[l]       = sel;
    assign wdata_o[8*l +: 8]  = sel ? byte_v : 8'h00;
  end
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
  import lsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_go_i,
  input  acc_ctrl_t         ctrl_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  acc_size_e        size_q;
  logic             sign_q;
  logic [OFF_W-1:0] off_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_BYTE;
      sign_q <= 1'b0;
      off_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_go_i;
      if (load_go_i) begin
        size_q <= ctrl_i.size;
        sign_q <= ctrl_i.is_signed;
        off_q  <= off_i;
      end
    end
  end

  logic [OFF_W-1:0]  bsel, hsel;
  logic [DATA_W-1:0] b_shift, h_shift;
  logic [7:0]        b_val;
  logic [15:0]       h_val;

  assign bsel    = OFF_W'(LANES - 1) - off_q;
  assign hsel    = OFF_W'(LANES - 2) - off_q;
  assign b_shift = rdata_i >> {bsel, 3'b000};
  assign h_shift = rdata_i >> {hsel, 3'b000};
  assign b_val   = b_shift[7:0];
  assign h_val   = h_shift[15:0];

  always_comb begin
    unique case (size_q)
      SZ_BYTE: data_o = {{(DATA_W-8){sign_q & b_val[7]}}, b_val};
      SZ_HALF: data_o = {{(DATA_W-16){sign_q & h_val[15]}}, h_val};
      default: data_o = rdata_i;
    endcase
  end

  assign done_o = done_q;
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic [5:0]                opcode_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic [DATA_W-1:0]         store_data_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-OFF_W-1:0]   mem_addr_o,
  output logic [LANES-1:0]          mem_be_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic                      misalign_o,
  output logic                      load_done_o,
  output logic [DATA_W-1:0]         load_data_o
);
  acc_ctrl_t         ctrl;
  logic [ADDR_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  logic [LANES-1:0]  lane_en;
  logic              bad_align;
  logic              live;

  lsu_decode u_dec (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  lsu_agu #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agu (
    .base_i (base_i),
    .disp_i (disp_i),
    .ea_o   (ea)
  );

  assign off = ea[OFF_W-1:0];

  lsu_store_path u_st (
    .ctrl_i       (ctrl),
    .off_i        (off),
    .store_data_i (store_data_i),
    .lane_en_o    (lane_en),
    .wdata_o      (mem_wdata_o),
    .misalign_o   (bad_align)
  );

  assign live        = req_i & ctrl.valid;
  assign misalign_o  = live & bad_align;
  assign mem_req_o   = live & ~bad_align;
  assign mem_we_o    = mem_req_o & ctrl.is_store;
  assign mem_addr_o  = ea[ADDR_W-1:OFF_W];
  assign mem_be_o    = mem_we_o ? lane_en : '0;

  lsu_load_path u_ld (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_go_i (mem_req_o & ~ctrl.is_store),
    .ctrl_i    (ctrl),
    .off_i     (off),
    .rdata_i   (mem_rdata_i),
    .done_o    (load_done_o),
    .data_o    (load_data_o)
  );
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_be_o,
  input logic       misalign_o,
  input logic       load_done_o
);
  logic load_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_prev <= 1'b0;
    else         load_prev <= mem_req_o & ~mem_we_o;
  end

  a_r5_misalign_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && !mem_we_o));

  a_r6_done_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_done_o);

  a_r6_done_only_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> load_prev);

  a_r3_store_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == 4));

  a_r3_load_no_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_be_o == 4'b0000));

  always_comb begin
    if (!rst_ni) a_r9_reset_quiet: assert (!load_done_o);
  end
endmodule

bind lsu_align_top lsu_align_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_be_o    (mem_be_o),
  .misalign_o  (misalign_o),
  .load_done_o (load_done_o)
);

// File: tb/lsu_align_top_tb_top.sv
module lsu_align_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  op = 6'h00;
  logic [31:0] base = '0;
  logic [15:0] disp = '0;
  logic [31:0] sdata = '0;
  logic        mem_req, mem_we, misalign, ld_done;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;
  logic [31:0] rdata_q = '0;
  logic [31:0] mem [16];

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  lsu_align_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .opcode_i(op), .base_i(base),
    .disp_i(disp), .store_data_i(sdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata_q), .misalign_o(misalign), .load_done_o(ld_done),
    .load_data_o(ld_data)
  );

  // memory model
  always @(posedge clk) begin
    if (mem_req) begin
      rdata_q <= mem[mem_addr[3:0]];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [5:0] o, input logic [1:0] f);
    case (o)
      6'h28:   return 4'b1000 >> f;
      6'h29:   return (f == 2'd0) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [5:0] o, input logic [1:0] f,
                                         input logic [31:0] d);
    case (o)
      6'h28:   return {24'h0, d[7:0]} << (8 * (3 - f));
      6'h29:   return {16'h0, d[15:0]} << (8 * (2 - f));
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] exp_ld(input logic [5:0] o, input logic [1:0] f,
                                         input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'(w >> (8 * (3 - f)));
    h = 16'(w >> (8 * (2 - f)));
    case (o)
      6'h20:   return {{24{b[7]}}, b};   // R7
      6'h24:   return {24'h0, b};        // R8
      6'h21:   return {{16{h[15]}}, h};  // R7
      6'h25:   return {16'h0, h};        // R8
      default: return w;                 // R8 word
    endcase
  endfunction

  task automatic issue(input logic [5:0] o, input logic [31:0] b, input logic [15:0] d,
                       input logic [31:0] sd);
    logic [31:0] ea;
    logic [1:0]  f;
    bit          valid, is_st, mis;
    @(negedge clk);
    req = 1'b1; op = o; base = b; disp = d; sdata = sd;
    #1;
    ea    = b + {{16{d[15]}}, d};
    f     = ea[1:0];
    valid = (o inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b});
    is_st = (o inside {6'h28, 6'h29, 6'h2b});
    mis   = valid && (((o == 6'h21 || o == 6'h25 || o == 6'h29) && f[0]) ||
                      ((o == 6'h23 || o == 6'h2b) && f != 2'd0));
    if (!valid) begin
      chk(!mem_req && !misalign, "R2 invalid opcode", {30'h0, misalign, mem_req}, 32'h0);
    end else if (mis) begin
      chk(misalign && !mem_req && !mem_we, "R5 misaligned", {29'h0, mem_we, mem_req, misalign},
          32'h1);
    end else begin
      chk(mem_req && !misalign, "R5 aligned accepted", {30'h0, misalign, mem_req}, 32'h1);
      chk(mem_addr == ea[31:2], "R1 word address", {2'b0, mem_addr}, {2'b0, ea[31:2]});
      if (is_st) begin
        chk(mem_we, "R3 write strobe", {31'h0, mem_we}, 32'h1);
        chk(mem_be == exp_be(o, f), "R3 lane enables", {28'h0, mem_be}, {28'h0, exp_be(o, f)});
        chk(mem_wdata == exp_wd(o, f, sd), "R4 lane data", mem_wdata, exp_wd(o, f, sd));
      end else begin
        chk(!mem_we && mem_be == 4'h0, "R3 load no lanes", {27'h0, mem_we, mem_be}, 32'h0);
        exp_q.push_back(exp_ld(o, f, mem[ea[5:2]]));
      end
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; op = 6'h00;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ld_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected load_done", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ld_data == e, "R7/R8 load data", ld_data, e);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 16; k++)
      mem[k] = (k % 2 == 0) ? 32'h80_7F_FF_01 + 32'(k) : 32'h7F_80_01_FF - 32'(k);
    repeat (3) @(posedge clk);
    #1;
    chk(!ld_done, "R9 reset quiet", {31'h0, ld_done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!mem_req && !ld_done, "R9 idle after reset", {30'h0, ld_done, mem_req}, 32'h0);

    // stores and signed/unsigned loads on word 0
    issue(6'h2b, 32'h0, 16'h0, 32'h8123_45F6);
    for (int f = 0; f < 4; f++) begin
      issue(6'h20, 32'h0, 16'(f), 32'h0);
      issue(6'h24, 32'h0, 16'(f), 32'h0);
    end
    issue(6'h21, 32'h0, 16'h0, 32'h0);
    issue(6'h25, 32'h0, 16'h0, 32'h0);
    issue(6'h21, 32'h0, 16'h2, 32'h0);
    issue(6'h25, 32'h0, 16'h2, 32'h0);
    issue(6'h23, 32'h0, 16'h0, 32'h0);

    // R1 negative displacement, byte and halfword stores
    issue(6'h28, 32'h8, 16'hFFFD, 32'hDEAD_BEA5);
    issue(6'h23, 32'h4, 16'h0, 32'h0);
    issue(6'h29, 32'h0, 16'h000A, 32'h1234_C0DE);
    issue(6'h29, 32'hC, 16'h0, 32'h1234_7A11);
    issue(6'h23, 32'h8, 16'h0, 32'h0);
    issue(6'h23, 32'hC, 16'h0, 32'h0);
    for (int f = 0; f < 4; f++) issue(6'h28, 32'h10, 16'(f), 32'(8'hA0 + f));
    issue(6'h23, 32'h10, 16'h0, 32'h0);

    // R5 misaligned accesses and no write
    issue(6'h21, 32'h0, 16'h1, 32'h0);
    issue(6'h23, 32'h0, 16'h2, 32'h0);
    issue(6'h2b, 32'h14, 16'h3, 32'hFFFF_FFFF);
    issue(6'h29, 32'h14, 16'h1, 32'hFFFF_FFFF);
    idle();
    chk(!ld_done, "R5 no done on misaligned load", {31'h0, ld_done}, 32'h0);
    issue(6'h23, 32'h14, 16'h0, 32'h0);

    // R2 unsupported opcodes
    issue(6'h22, 32'h0, 16'h0, 32'h0);
    issue(6'h2a, 32'h0, 16'h0, 32'h0);
    issue(6'h00, 32'h0, 16'h0, 32'h0);
    idle();
    chk(!ld_done, "R2 no done on bad opcode", {31'h0, ld_done}, 32'h0);

    // R1 large base with negative displacement
    issue(6'h23, 32'h1000_0000, 16'h8004, 32'h0);
    issue(6'h2b, 32'h0000_0020, 16'h0018, 32'h0BAD_F00D);
    issue(6'h24, 32'h0000_0038, 16'h0002, 32'h0);

    // R6 store gives no done
    issue(6'h28, 32'h4, 16'h0, 32'h55);
    idle();
    @(negedge clk);
    chk(!ld_done, "R6 no done after store", {31'h0, ld_done}, 32'h0);
    chk(exp_q.size() == 0, "R6 every load completed", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule